// File: doc/BRIEF.md
# Serial Adapter Register File and Interrupt Controller

This block is the processor side of an asynchronous serial adapter. A two-bit register index, a chip select and a write flag reach four locations: a shared data slot (transmit byte on write, received byte on read), a status byte that doubles as a soft-reset trigger on write, a command register and a configuration register. The block keeps the holding registers for both directions and the flags around them. It produces one active-low interrupt and the two active-low modem handshake outputs. The transmitter and receiver engines sit outside and talk to it through single-cycle pulses.

Two modem inputs, carrier detect and data-set ready, are watched for changes. The first change captures the new levels, raises an interrupt and freezes the captured copy. A status read releases the freeze, and if a line moved in the meantime a fresh interrupt follows at once. Writes to the status index perform a partial reset. This reset keeps the configuration register and any pending transmit or receive interrupt, and drops only the modem-caused request. All inputs are taken as synchronous to `clk`, and `rst` is a synchronous active-high hardware reset.

Top module: `sio_ctrl_regs`

## Requirements
- R1: Index 0 written with `sel`=1, `wr`=1 stores `wdata` in the transmit holding register (`tx_data`) and pulses `tx_load` for one cycle. Index 0 read returns the last accepted received byte and pulses `rx_read`. Index 2 (command) and index 3 (configuration) read back what was written.
- R2: The status byte has this layout: bit 7 interrupt pending, bit 6 captured data-set-ready level, bit 5 captured carrier level, bit 4 transmit holder empty, bit 3 receive holder full, bit 2 overrun, bit 1 framing error, bit 0 parity error. The three error bits never cause an interrupt.
- R3: The transmit-empty flag is cleared by a data write, and it is set by a `tx_taken` pulse when no data write occurs in the same cycle.
- R4: If `rx_load` arrives while the receive holder is empty, it stores `rx_byte`, `rx_pe` and `rx_fe` and sets the full flag. If it arrives while the holder is full and unread, it keeps the old byte and sets overrun. A data read clears full, overrun, framing and parity.
- R5: The interrupt is raised by `tx_taken` when command bits 3:2 = 01 and bit 0 = 1. It is also raised by `rx_load` when command bit 1 = 0 and bit 0 = 1. A status read clears it unless a new event arrives in that same cycle.
- R6: A change of either modem line, with command bit 0 = 1, captures both levels and raises the interrupt. Later changes leave the captured bits unchanged until a status read.
- R7: When a status read ends a freeze and a modem line differs from its captured copy, the interrupt is raised again one cycle after the read.
- R8: While command bit 0 = 0 no new interrupt is raised from any source, and the captured modem bits simply follow the lines.
- R9: `dtr_n` is low exactly when command bit 0 = 1. `rts_n` is high only when command bits 4:2 = 000. `tx_break` is high when bits 3:2 = 11.
- R10: Hardware reset clears the command and configuration registers and the interrupt, sets transmit-empty, clears the receive and error flags, and loads the modem bits from the lines.
- R11: A write to index 1 clears command bits 4:0 and overrun, keeps the configuration register, releases a modem-caused interrupt and keeps a pending transmit or receive interrupt.
- R12: Read data is registered and appears on `rdata` one cycle after the access. An access with `sel` = 0 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| sel | input | 1 | Chip select; one access per selected cycle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 2 | Register index |
| wdata | input | DW | Write data |
| rdata | output | DW | Registered read data |
| tx_taken | input | 1 | Transmitter moved the holding byte into its shifter |
| rx_load | input | 1 | Receiver offers a finished character |
| rx_byte | input | DW | Received character |
| rx_pe | input | 1 | Parity error of the offered character |
| rx_fe | input | 1 | Framing error of the offered character |
| dcd_n | input | 1 | Carrier-detect line, active low |
| dsr_n | input | 1 | Data-set-ready line, active low |
| tx_data | output | DW | Transmit holding register |
| tx_load | output | 1 | One-cycle pulse after a data write |
| rx_read | output | 1 | One-cycle pulse after a data read |
| cmd_q | output | 8 | Command register |
| ctl_q | output | 8 | Configuration register |
| tx_break | output | 1 | Break request to the transmitter |
| rts_n | output | 1 | Request-to-send, active low |
| dtr_n | output | 1 | Terminal-ready, active low |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
Every register result, flag, strobe and interrupt change is due one clock edge after the stimulus that causes it. The one exception is the modem re-interrupt, which is due two edges after the status read: one edge clears the freeze and the next edge sees the difference. The bench drives inputs and samples outputs on falling edges. Each check therefore reads the value settled after exactly the intended number of rising edges, and the re-interrupt is checked at both points: still high after the read, low one cycle later.

// File: rtl/sio_ctrl_pkg.sv
package sio_ctrl_pkg;
  localparam int unsigned IDX_W  = 2;
  localparam int unsigned CFG_W  = 8;
  localparam int unsigned NMODEM = 2;

  typedef enum logic [IDX_W-1:0] {
    IDX_DATA = 2'd0,
    IDX_STAT = 2'd1,
    IDX_CMD  = 2'd2,
    IDX_CTL  = 2'd3
  } reg_idx_e;

  typedef struct packed {
    logic wr_data;
    logic rd_data;
    logic rd_stat;
    logic soft_rst;
    logic wr_cmd;
    logic rd_cmd;
    logic wr_ctl;
    logic rd_ctl;
  } bus_strobe_t;

  // modem line order inside the watch vector: [1] = data set ready, [0] = carrier
  localparam int unsigned ML_DCD = 0;
  localparam int unsigned ML_DSR = 1;
endpackage

// File: rtl/sio_bus_decode.sv
module sio_bus_decode
  import sio_ctrl_pkg::*;
(
  input  logic             sel,
  input  logic             wr,
  input  logic [IDX_W-1:0] addr,
  output bus_strobe_t      st
);
  reg_idx_e idx;
  assign idx = reg_idx_e'(addr);

  always_comb begin
    st = '0;
    if (sel) begin
      unique case (idx)
        IDX_DATA: begin st.wr_data = wr;  st.rd_data = !wr; end
        IDX_STAT: begin st.soft_rst = wr; st.rd_stat = !wr; end
        IDX_CMD:  begin st.wr_cmd = wr;   st.rd_cmd = !wr;  end
        IDX_CTL:  begin st.wr_ctl = wr;   st.rd_ctl = !wr;  end
        default:  st = '0;
      endcase
    end
  end
endmodule

// File: rtl/sio_modem_watch.sv
module sio_modem_watch #(
  parameter int unsigned NLINES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] line_n,
  input  logic              en,
  input  logic              rd_stat,
  input  logic              soft_rst,
  output logic [NLINES-1:0] cap,
  output logic              evt
);
  logic              frozen;
  logic [NLINES-1:0] diff;
  logic              moved;

  for (genvar i = 0; i < NLINES; i++) begin : g_cmp
    assign diff[i] = line_n[i] ^ cap[i];
  end
  assign moved = |diff;
  assign evt   = moved && en && !frozen && !soft_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap    <= line_n;
      frozen <= 1'b0;
    end else begin
      if (!frozen && moved) cap <= line_n;
      if (evt)                       frozen <= 1'b1;
      else if (rd_stat || soft_rst)  frozen <= 1'b0;
    end
  end

  a_r6_frozen_hold: assert property (@(posedge clk) disable iff (rst)
    (frozen && !rd_stat && !soft_rst) |=> $stable(cap));
  a_r6_capture_level: assert property (@(posedge clk) disable iff (rst)
    evt |=> (cap == $past(line_n)));
endmodule

// File: rtl/sio_irq_unit.sv
module sio_irq_unit (
  input  logic clk,
  input  logic rst,
  input  logic tx_evt,
  input  logic rx_evt,
  input  logic mod_evt,
  input  logic rd_stat,
  input  logic soft_rst,
  output logic irq
);
  logic pend_data;
  logic pend_mod;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_data <= 1'b0;
      pend_mod  <= 1'b0;
    end else begin
      if (tx_evt || rx_evt) pend_data <= 1'b1;
      else if (rd_stat)     pend_data <= 1'b0;
      if (mod_evt)                    pend_mod <= 1'b1;
      else if (rd_stat || soft_rst)   pend_mod <= 1'b0;
    end
  end

  assign irq = pend_data | pend_mod;

  a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && !tx_evt && !rx_evt && !mod_evt) |=> !irq);
  a_r11_mod_release: assert property (@(posedge clk) disable iff (rst)
    (soft_rst && !pend_data && !tx_evt && !rx_evt && !mod_evt) |=> !irq);
  a_r5_event_raises: assert property (@(posedge clk) disable iff (rst)
    (tx_evt || rx_evt || mod_evt) |=> irq);
endmodule

// File: rtl/sio_data_path.sv
module sio_data_path #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_data,
  input  logic          rd_data,
  input  logic          soft_rst,
  input  logic [DW-1:0] wdata,
  input  logic          tx_taken,
  input  logic          rx_load,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_pe,
  input  logic          rx_fe,
  output logic [DW-1:0] tx_hold,
  output logic [DW-1:0] rx_hold,
  output logic          tdre,
  output logic          rdrf,
  output logic          ovr,
  output logic          fe,
  output logic          pe
);
  logic still_full;
  logic accept;
  assign still_full = rdrf && !rd_data;
  assign accept     = rx_load && !still_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_hold <= '0;
      tdre    <= 1'b1;
    end else begin
      if (wr_data) tx_hold <= wdata;
      if (wr_data)       tdre <= 1'b0;
      else if (tx_taken) tdre <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_hold <= '0;
      rdrf    <= 1'b0;
      ovr     <= 1'b0;
      fe      <= 1'b0;
      pe      <= 1'b0;
    end else begin
      if (accept) begin
        rx_hold <= rx_byte;
        rdrf    <= 1'b1;
        pe      <= rx_pe;
        fe      <= rx_fe;
      end else if (rd_data) begin
        rdrf <= 1'b0;
        pe   <= 1'b0;
        fe   <= 1'b0;
      end
      if (rx_load && still_full)     ovr <= 1'b1;
      else if (rd_data || soft_rst)  ovr <= 1'b0;
    end
  end

  a_r3_write_clears: assert property (@(posedge clk) disable iff (rst)
    wr_data |=> !tdre);
  a_r3_taken_sets: assert property (@(posedge clk) disable iff (rst)
    (tx_taken && !wr_data) |=> tdre);
  a_r4_overrun_keeps: assert property (@(posedge clk) disable iff (rst)
    (rx_load && rdrf && !rd_data) |=> (ovr && rdrf && $stable(rx_hold)));
  a_r4_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_data && !rx_load) |=> (!rdrf && !ovr && !pe && !fe));
endmodule

// File: rtl/sio_ctrl_regs.sv
module sio_ctrl_regs
  import sio_ctrl_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic             wr,
  input  logic [IDX_W-1:0] addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic             tx_taken,
  input  logic             rx_load,
  input  logic [DW-1:0]    rx_byte,
  input  logic             rx_pe,
  input  logic             rx_fe,
  input  logic             dcd_n,
  input  logic             dsr_n,
  output logic [DW-1:0]    tx_data,
  output logic             tx_load,
  output logic             rx_read,
  output logic [CFG_W-1:0] cmd_q,
  output logic [CFG_W-1:0] ctl_q,
  output logic             tx_break,
  output logic             rts_n,
  output logic             dtr_n,
  output logic             irq_n
);
  bus_strobe_t       st;
  logic [NMODEM-1:0] lines_n;
  logic [NMODEM-1:0] mcap;
  logic              mod_evt;
  logic              tx_evt;
  logic              rx_evt;
  logic              irq;
  logic [DW-1:0]     rx_hold;
  logic              tdre, rdrf, ovr, fe, pe;
  logic [CFG_W-1:0]  stat_b;
  logic [DW-1:0]     stat_w, cmd_w, ctl_w;
  logic              ints_on;

  sio_bus_decode u_dec (
    .sel  (sel),
    .wr   (wr),
    .addr (addr),
    .st   (st)
  );

  // command and configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      ctl_q <= '0;
    end else begin
      if (st.wr_cmd)        cmd_q <= wdata[CFG_W-1:0];
      else if (st.soft_rst) cmd_q <= {cmd_q[7:5], 5'b00000};
      if (st.wr_ctl)        ctl_q <= wdata[CFG_W-1:0];
    end
  end

  assign ints_on = cmd_q[0];
  assign tx_evt  = tx_taken && ints_on && (cmd_q[3:2] == 2'b01);
  assign rx_evt  = rx_load  && ints_on && !cmd_q[1];

  assign lines_n[ML_DCD] = dcd_n;
  assign lines_n[ML_DSR] = dsr_n;

  sio_modem_watch #(.NLINES(NMODEM)) u_mod (
    .clk      (clk),
    .rst      (rst),
    .line_n   (lines_n),
    .en       (ints_on),
    .rd_stat  (st.rd_stat),
    .soft_rst (st.soft_rst),
    .cap      (mcap),
    .evt      (mod_evt)
  );

  sio_irq_unit u_irq (
    .clk      (clk),
    .rst      (rst),
    .tx_evt   (tx_evt),
    .rx_evt   (rx_evt),
    .mod_evt  (mod_evt),
    .rd_stat  (st.rd_stat),
    .soft_rst (st.soft_rst),
    .irq      (irq)
  );

  sio_data_path #(.DW(DW)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .wr_data  (st.wr_data),
    .rd_data  (st.rd_data),
    .soft_rst (st.soft_rst),
    .wdata    (wdata),
    .tx_taken (tx_taken),
    .rx_load  (rx_load),
    .rx_byte  (rx_byte),
    .rx_pe    (rx_pe),
    .rx_fe    (rx_fe),
    .tx_hold  (tx_data),
    .rx_hold  (rx_hold),
    .tdre     (tdre),
    .rdrf     (rdrf),
    .ovr      (ovr),
    .fe       (fe),
    .pe       (pe)
  );

  assign stat_b = {irq, mcap[ML_DSR], mcap[ML_DCD], tdre, rdrf, ovr, fe, pe};

  always_comb begin
    stat_w = '0;
    stat_w[CFG_W-1:0] = stat_b;
    cmd_w = '0;
    cmd_w[CFG_W-1:0] = cmd_q;
    ctl_w = '0;
    ctl_w[CFG_W-1:0] = ctl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      tx_load <= 1'b0;
      rx_read <= 1'b0;
    end else begin
      tx_load <= st.wr_data;
      rx_read <= st.rd_data;
      if (st.rd_data)      rdata <= rx_hold;
      else if (st.rd_stat) rdata <= stat_w;
      else if (st.rd_cmd)  rdata <= cmd_w;
      else if (st.rd_ctl)  rdata <= ctl_w;
    end
  end

  assign dtr_n    = !cmd_q[0];
  assign rts_n    = (cmd_q[4:2] == 3'b000);
  assign tx_break = (cmd_q[3:2] == 2'b11);
  assign irq_n    = !irq;

  a_r11_soft_lines: assert property (@(posedge clk) disable iff (rst)
    (st.soft_rst && !st.wr_cmd) |=> (dtr_n && rts_n && !tx_break && $stable(ctl_q)));
  a_r8_no_new_irq: assert property (@(posedge clk) disable iff (rst)
    (!cmd_q[0] && irq_n) |=> irq_n);
  a_r12_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !sel |=> ($stable(cmd_q) && $stable(ctl_q) && $stable(tx_data)));
  a_r2_err_no_irq: assert property (@(posedge clk) disable iff (rst)
    (irq_n && !tx_evt && !rx_evt && !mod_evt) |=> irq_n);
endmodule

// File: tb/sio_ctrl_regs_bench.sv
module sio_ctrl_regs_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel = 1'b0, wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tx_taken = 1'b0, rx_load = 1'b0, rx_pe = 1'b0, rx_fe = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       dcd_n = 1'b1, dsr_n = 1'b1;
  logic [7:0] tx_data, cmd_q, ctl_q;
  logic       tx_load, rx_read, tx_break, rts_n, dtr_n, irq_n;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  int cyc   = 0;

  always #10 clk = !clk;

  sio_ctrl_regs u_sio_ctrl_regs (
    .clk(clk), .rst(rst), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tx_taken(tx_taken), .rx_load(rx_load), .rx_byte(rx_byte),
    .rx_pe(rx_pe), .rx_fe(rx_fe), .dcd_n(dcd_n), .dsr_n(dsr_n),
    .tx_data(tx_data), .tx_load(tx_load), .rx_read(rx_read), .cmd_q(cmd_q),
    .ctl_q(ctl_q), .tx_break(tx_break), .rts_n(rts_n), .dtr_n(dtr_n),
    .irq_n(irq_n)
  );

  // {is_write, index, data, expected read value}
  localparam int NVEC = 11;
  localparam logic [18:0] VEC [0:NVEC-1] = '{
    {1'b1, 2'd3, 8'hA5, 8'h00},
    {1'b0, 2'd3, 8'h00, 8'hA5},
    {1'b1, 2'd2, 8'hE9, 8'h00},
    {1'b0, 2'd2, 8'h00, 8'hE9},
    {1'b0, 2'd1, 8'h00, 8'h70},
    {1'b1, 2'd0, 8'h3C, 8'h00},
    {1'b0, 2'd1, 8'h00, 8'h60},
    {1'b1, 2'd1, 8'h00, 8'h00},
    {1'b0, 2'd2, 8'h00, 8'hE0},
    {1'b0, 2'd3, 8'h00, 8'hA5},
    {1'b0, 2'd1, 8'h00, 8'h60}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] q);
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk); sel = 1'b0; q = rdata;
  endtask

  task automatic pulse_tx();
    @(negedge clk); tx_taken = 1'b1;
    @(negedge clk); tx_taken = 1'b0;
  endtask

  task automatic pulse_rx(input logic [7:0] b, input logic p, input logic f);
    @(negedge clk); rx_load = 1'b1; rx_byte = b; rx_pe = p; rx_fe = f;
    @(negedge clk); rx_load = 1'b0; rx_pe = 1'b0; rx_fe = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [7:0] q;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 irq_n", {7'd0, irq_n}, 8'h01);
    check("R10 dtr_n", {7'd0, dtr_n}, 8'h01);
    check("R10 rts_n", {7'd0, rts_n}, 8'h01);
    check("R10 cmd", cmd_q, 8'h00);
    check("R10 ctl", ctl_q, 8'h00);
    bus_rd(2'd1, q); check("R10 status", q, 8'h70);

    // vector table: R1 R2 R3 R11 R12
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][18]) bus_wr(VEC[i][17:16], VEC[i][15:8]);
      else begin
        bus_rd(VEC[i][17:16], q);
        check($sformatf("R1/R2/R3/R11 table entry %0d", i), q, VEC[i][7:0]);
      end
    end
    check("R1 tx_data from table", tx_data, 8'h3C);

    // R9 line decode
    bus_wr(2'd2, 8'h00);
    check("R9 dtr off", {6'd0, dtr_n, rts_n}, 8'h03);
    bus_wr(2'd2, 8'h01);
    check("R9 dtr on", {6'd0, dtr_n, rts_n}, 8'h01);
    bus_wr(2'd2, 8'h05);
    check("R9 rts on", {6'd0, dtr_n, rts_n}, 8'h00);
    bus_wr(2'd2, 8'h0D);
    check("R9 break", {6'd0, tx_break, rts_n}, 8'h02);
    bus_wr(2'd2, 8'h11);
    check("R9 echo rts", {6'd0, tx_break, rts_n}, 8'h00);

    // R1 transmit write strobe
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = 2'd0; wdata = 8'h81;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
    check("R1 tx_load pulse", {7'd0, tx_load}, 8'h01);
    check("R1 tx_data", tx_data, 8'h81);
    @(negedge clk);
    check("R1 tx_load one cycle", {7'd0, tx_load}, 8'h00);

    // R5 and R3 transmit interrupt
    bus_wr(2'd2, 8'h05);
    pulse_tx();
    check("R5 tx irq", {7'd0, irq_n}, 8'h00);
    bus_rd(2'd1, q); check("R3 R5 status", q, 8'hF0);
    check("R5 read clears", {7'd0, irq_n}, 8'h01);

    // R4 receive and overrun
    pulse_rx(8'h5A, 1'b1, 1'b0);
    check("R5 rx irq", {7'd0, irq_n}, 8'h00);
    pulse_rx(8'h11, 1'b0, 1'b1);
    bus_rd(2'd1, q); check("R4 overrun status", q, 8'hFD);
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = 2'd0;
    @(negedge clk); sel = 1'b0;
    check("R4 kept byte", rdata, 8'h5A);
    check("R1 rx_read pulse", {7'd0, rx_read}, 8'h01);
    bus_rd(2'd1, q); check("R4 flags cleared", q, 8'h70);

    // R2 errors alone raise nothing
    bus_wr(2'd2, 8'h07);
    pulse_rx(8'h22, 1'b0, 1'b1);
    check("R2 no irq on error", {7'd0, irq_n}, 8'h01);
    bus_rd(2'd1, q); check("R2 layout", q, 8'h7A);
    bus_rd(2'd0, q); check("R4 byte", q, 8'h22);

    // R6 and R7 modem freeze and re-interrupt
    bus_wr(2'd2, 8'h01);
    @(negedge clk); dcd_n = 1'b0;
    @(negedge clk);
    check("R6 modem irq", {7'd0, irq_n}, 8'h00);
    dcd_n = 1'b1;
    @(negedge clk);
    bus_rd(2'd1, q); check("R6 frozen level", q, 8'hD0);
    check("R7 cleared by read", {7'd0, irq_n}, 8'h01);
    @(negedge clk);
    check("R7 re-interrupt", {7'd0, irq_n}, 8'h00);
    bus_rd(2'd1, q); check("R7 new level", q, 8'hF0);
    check("R7 settled", {7'd0, irq_n}, 8'h01);

    // R8 disabled: follow, no interrupt
    bus_wr(2'd2, 8'h00);
    @(negedge clk); dsr_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 no irq", {7'd0, irq_n}, 8'h01);
    bus_rd(2'd1, q); check("R8 follows", q, 8'h30);
    dsr_n = 1'b1;
    repeat (2) @(negedge clk);

    // R11 modem request released, data request kept
    bus_wr(2'd2, 8'h01);
    @(negedge clk); dsr_n = 1'b0;
    @(negedge clk);
    check("R11 modem irq set", {7'd0, irq_n}, 8'h00);
    bus_wr(2'd1, 8'h00);
    check("R11 modem released", {6'd0, irq_n, dtr_n}, 8'h03);
    bus_rd(2'd1, q); check("R11 status", q, 8'h30);
    dsr_n = 1'b1;
    repeat (2) @(negedge clk);
    bus_wr(2'd2, 8'h05);
    pulse_tx();
    bus_wr(2'd1, 8'h00);
    check("R11 tx request kept", {7'd0, irq_n}, 8'h00);
    bus_rd(2'd1, q); check("R11 kept status", q, 8'hF0);

    // R12 unselected write ignored
    @(negedge clk); sel = 1'b0; wr = 1'b1; addr = 2'd3; wdata = 8'h3C;
    @(negedge clk); wr = 1'b0;
    bus_rd(2'd3, q); check("R12 unselected", q, 8'hA5);

    // R10 hardware reset during operation
    @(negedge clk); dcd_n = 1'b0; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 cmd cleared", cmd_q, 8'h00);
    check("R10 ctl cleared", ctl_q, 8'h00);
    check("R10 irq idle", {7'd0, irq_n}, 8'h01);
    bus_rd(2'd1, q); check("R10 lines loaded", q, 8'h50);

    finish_run();
  end
endmodule